// File: doc/BRIEF.md
# Dual-Port Semaphore Flag Bank

This block holds a set of hardware ownership flags shared by two masters, a left port and a right port. It normally sits beside a shared memory so that both sides can agree on who may touch a region. A master claims a flag by writing a request to it. It then reads the flag back: a reading of all zeros means it now owns the flag, and all ones means the flag is free or held by the other side. The owner hands the flag back by writing a release.

Both ports have the same interface. Each has a 3-bit flag index, a flag-select strobe, a chip-enable input, a write strobe, an output enable, an 8-bit write bus and an 8-bit read bus. A flag access takes place only while the flag select is high and the chip enable is low; the chip enable belongs to the neighbouring memory.

A request that arrives while the other side holds the flag is not dropped. It waits, and the flag moves to the waiting side on the same edge that records the holder's release. When both sides ask for a free flag in the same cycle, a per-flag priority bit picks the winner and then flips. There are no streams here, so every pin is a plain level or strobe with no valid/ready handshake. A write is recorded on the rising clock edge. A read is combinational from the registered flag state.

Top module: `sema_bank`

## Requirements
- R1: After reset every flag is free, and a read of any flag from either port returns 8'hFF.
- R2: A write with bit 0 equal to 0 requests the indexed flag. If the flag is free, the writer owns it from the next cycle: the writer reads 8'h00 and the other port reads 8'hFF.
- R3: A write or read takes effect only when flag select is 1 and chip enable is 0. A write made with select 0 or with chip enable 1 leaves every flag unchanged.
- R4: The read bus carries the flag value on all 8 bits (8'h00 or 8'hFF). It is 8'h00 unless select is 1, chip enable is 0, write strobe is 0 and output enable is 1.
- R5: A write with bit 0 equal to 1 from the owner releases the flag. With no waiter, both ports then read 8'hFF.
- R6: A request to a flag held by the other port stays pending, and the owner keeps the flag until it releases. On the edge that records the release, ownership passes to the pending side, which reads 8'h00 in the next cycle.
- R7: When both ports request the same free flag in the same cycle, exactly one wins. Each flag has its own priority bit, which after reset favours the left port and flips after every such tie. The loser stays pending.
- R8: Writes from the two ports to different flags in the same cycle both take effect.
- R9: A release from a port that neither owns nor waits for a flag has no effect. A release from the waiting port withdraws its request, so the flag does not pass to it.
- R10: The right port behaves exactly like the left, up to flag index 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| l_addr | input | 3 | Left flag index |
| l_flag_sel | input | 1 | Left flag select, active high |
| l_chip_en | input | 1 | Left memory enable; must be 0 for a flag access |
| l_wr | input | 1 | Left strobe: 1 write, 0 read |
| l_out_en | input | 1 | Left output enable |
| l_wdata | input | 8 | Left write bus; bit 0 selects request (0) or release (1) |
| l_rdata | output | 8 | Left read bus |
| r_addr | input | 3 | Right flag index |
| r_flag_sel | input | 1 | Right flag select, active high |
| r_chip_en | input | 1 | Right memory enable; must be 0 for a flag access |
| r_wr | input | 1 | Right strobe: 1 write, 0 read |
| r_out_en | input | 1 | Right output enable |
| r_wdata | input | 8 | Right write bus; bit 0 selects request (0) or release (1) |
| r_rdata | output | 8 | Right read bus |

## Verification
A write is recorded on one rising edge. Its result, including a hand-over to a waiting port, is visible on the read buses during the cycle that follows. A read is combinational and shows up within the same cycle. The bench therefore drives each write for exactly one edge, switches both ports to a read at the next falling edge, and samples the read buses a quarter period later, before the following rising edge. The gating cases for R3 and R4 are sampled in the same cycle they are set up.

// File: rtl/sema_pkg.sv
package sema_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/sema_port_dec.sv
module sema_port_dec #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  localparam int NUM_FLAGS = 1 << ADDR_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 flag_sel,
  input  logic                 chip_en,
  input  logic                 wr,
  input  logic                 out_en,
  input  logic                 wbit,
  input  logic [NUM_FLAGS-1:0] held_vec,
  output logic [NUM_FLAGS-1:0] req_vec,
  output logic [NUM_FLAGS-1:0] rel_vec,
  output logic [DATA_W-1:0]    rdata
);
  logic access, wr_hit, rd_hit;

  assign access = flag_sel & ~chip_en;
  assign wr_hit = access & wr;
  assign rd_hit = access & ~wr & out_en;

  always_comb begin
    req_vec = '0;
    rel_vec = '0;
    if (wr_hit) begin
      if (wbit) rel_vec[addr] = 1'b1;
      else      req_vec[addr] = 1'b1;
    end
  end

  assign rdata = rd_hit ? {DATA_W{~held_vec[addr]}} : '0;

  // R4: flag value replicated across the whole bus
  p_read_replicated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata == '0) || (rdata == '1));

  // R3: no command leaves a port without a qualified write
  p_cmd_needs_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_sel && !chip_en && wr) |-> ((req_vec | rel_vec) == '0));
endmodule

// File: rtl/sema_flag_cell.sv
module sema_flag_cell
  import sema_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_l,
  input  logic rel_l,
  input  logic req_r,
  input  logic rel_r,
  output logic held_l,
  output logic held_r
);
  logic   want_l, want_r, want_l_nx, want_r_nx;
  logic   prio, prio_nx;
  owner_e owner, owner_nx;

  assign want_l_nx = rel_l ? 1'b0 : (req_l ? 1'b1 : want_l);
  assign want_r_nx = rel_r ? 1'b0 : (req_r ? 1'b1 : want_r);

  always_comb begin
    owner_nx = owner;
    prio_nx  = prio;
    unique case (owner)
      OWN_LEFT: begin
        if (!want_l_nx) owner_nx = want_r_nx ? OWN_RIGHT : OWN_NONE;
      end
      OWN_RIGHT: begin
        if (!want_r_nx) owner_nx = want_l_nx ? OWN_LEFT : OWN_NONE;
      end
      default: begin
        if (want_l_nx && want_r_nx) begin
          owner_nx = prio ? OWN_RIGHT : OWN_LEFT;
          prio_nx  = ~prio;
        end else if (want_l_nx) begin
          owner_nx = OWN_LEFT;
        end else if (want_r_nx) begin
          owner_nx = OWN_RIGHT;
        end else begin
          owner_nx = OWN_NONE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      want_l <= 1'b0;
      want_r <= 1'b0;
      prio   <= 1'b0;
      owner  <= OWN_NONE;
    end else begin
      want_l <= want_l_nx;
      want_r <= want_r_nx;
      prio   <= prio_nx;
      owner  <= owner_nx;
    end
  end

  assign held_l = (owner == OWN_LEFT);
  assign held_r = (owner == OWN_RIGHT);

  // R6: owner keeps the flag until it releases
  p_hold_left_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_LEFT && !rel_l) |=> (owner == OWN_LEFT));
  p_hold_right_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_RIGHT && !rel_r) |=> (owner == OWN_RIGHT));

  // R6: release hands the flag to a pending waiter
  p_pass_to_right_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_LEFT && rel_l && want_r && !rel_r) |=> (owner == OWN_RIGHT));

  // R7: a same-cycle tie grants someone and flips priority
  p_tie_granted_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_NONE && req_l && req_r) |=> (owner != OWN_NONE && prio != $past(prio)));

  // R5: a free flag has nobody waiting
  p_free_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_NONE) |-> (!want_l && !want_r));
endmodule

// File: rtl/sema_bank.sv
module sema_bank #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  localparam int NUM_FLAGS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_flag_sel,
  input  logic              l_chip_en,
  input  logic              l_wr,
  input  logic              l_out_en,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_flag_sel,
  input  logic              r_chip_en,
  input  logic              r_wr,
  input  logic              r_out_en,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);
  logic [NUM_FLAGS-1:0] req_l, rel_l, req_r, rel_r, held_l, held_r;
  logic                 unused_wdata_hi;

  assign unused_wdata_hi = ^{l_wdata[DATA_W-1:1], r_wdata[DATA_W-1:1]};

  sema_port_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_l (
    .clk(clk), .rst_n(rst_n), .addr(l_addr), .flag_sel(l_flag_sel),
    .chip_en(l_chip_en), .wr(l_wr), .out_en(l_out_en), .wbit(l_wdata[0]),
    .held_vec(held_l), .req_vec(req_l), .rel_vec(rel_l), .rdata(l_rdata)
  );

  sema_port_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_r (
    .clk(clk), .rst_n(rst_n), .addr(r_addr), .flag_sel(r_flag_sel),
    .chip_en(r_chip_en), .wr(r_wr), .out_en(r_out_en), .wbit(r_wdata[0]),
    .held_vec(held_r), .req_vec(req_r), .rel_vec(rel_r), .rdata(r_rdata)
  );

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    sema_flag_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .req_l(req_l[g]), .rel_l(rel_l[g]),
      .req_r(req_r[g]), .rel_r(rel_r[g]),
      .held_l(held_l[g]), .held_r(held_r[g])
    );
  end

  // R7 / R10: never both ports reading ownership of the same flag
  p_excl_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_flag_sel && !l_chip_en && !l_wr && l_out_en &&
      r_flag_sel && !r_chip_en && !r_wr && r_out_en &&
      l_addr == r_addr && l_rdata == '0 && r_rdata == '0));
endmodule

// File: tb/sema_bank_bench.sv
module sema_bank_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] l_addr = '0, r_addr = '0;
  logic       l_sel = 0, l_ce = 0, l_wr = 0, l_oe = 0;
  logic       r_sel = 0, r_ce = 0, r_wr = 0, r_oe = 0;
  logic [7:0] l_wdata = '0, r_wdata = '0;
  logic [7:0] l_rdata, r_rdata;
  int         n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  sema_bank u_sema_bank (
    .clk(clk), .rst_n(rst_n),
    .l_addr(l_addr), .l_flag_sel(l_sel), .l_chip_en(l_ce), .l_wr(l_wr),
    .l_out_en(l_oe), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_addr(r_addr), .r_flag_sel(r_sel), .r_chip_en(r_ce), .r_wr(r_wr),
    .r_out_en(r_oe), .r_wdata(r_wdata), .r_rdata(r_rdata)
  );

  // Vector: [22] l write, [21] l bit0, [20:18] l addr, [17] r write,
  // [16] r bit0, [15:13] r addr, [12:10] check addr, [9] exp l all-ones,
  // [8] exp r all-ones, [7:0] requirement number
  localparam int NV = 19;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1,1'b0,3'd0, 1'b0,1'b0,3'd0, 3'd0, 1'b0,1'b1, 8'd2},   // R2 left claims 0
    {1'b0,1'b0,3'd0, 1'b1,1'b0,3'd0, 3'd0, 1'b0,1'b1, 8'd6},   // R6 right waits
    {1'b1,1'b1,3'd0, 1'b0,1'b0,3'd0, 3'd0, 1'b1,1'b0, 8'd6},   // R6 hand-over
    {1'b0,1'b0,3'd0, 1'b1,1'b1,3'd0, 3'd0, 1'b1,1'b1, 8'd5},   // R5 release
    {1'b1,1'b0,3'd1, 1'b1,1'b0,3'd1, 3'd1, 1'b0,1'b1, 8'd7},   // R7 tie, left first
    {1'b1,1'b1,3'd1, 1'b0,1'b0,3'd0, 3'd1, 1'b1,1'b0, 8'd6},   // R6 loser gets it
    {1'b0,1'b0,3'd0, 1'b1,1'b1,3'd1, 3'd1, 1'b1,1'b1, 8'd5},   // R5
    {1'b1,1'b0,3'd1, 1'b1,1'b0,3'd1, 3'd1, 1'b1,1'b0, 8'd7},   // R7 tie, right now
    {1'b0,1'b0,3'd0, 1'b1,1'b1,3'd1, 3'd1, 1'b0,1'b1, 8'd6},   // R6 left gets it
    {1'b1,1'b1,3'd1, 1'b0,1'b0,3'd0, 3'd1, 1'b1,1'b1, 8'd5},   // R5
    {1'b1,1'b0,3'd3, 1'b1,1'b0,3'd4, 3'd3, 1'b0,1'b1, 8'd8},   // R8 split flags
    {1'b0,1'b0,3'd0, 1'b0,1'b0,3'd0, 3'd4, 1'b1,1'b0, 8'd8},   // R8
    {1'b1,1'b1,3'd4, 1'b0,1'b0,3'd0, 3'd4, 1'b1,1'b0, 8'd9},   // R9 stray release
    {1'b0,1'b0,3'd0, 1'b1,1'b0,3'd3, 3'd3, 1'b0,1'b1, 8'd6},   // R6 right waits
    {1'b0,1'b0,3'd0, 1'b1,1'b1,3'd3, 3'd3, 1'b0,1'b1, 8'd9},   // R9 withdraw
    {1'b1,1'b1,3'd3, 1'b0,1'b0,3'd0, 3'd3, 1'b1,1'b1, 8'd9},   // R9 no pass
    {1'b0,1'b0,3'd0, 1'b1,1'b1,3'd4, 3'd4, 1'b1,1'b1, 8'd5},   // R5
    {1'b0,1'b0,3'd0, 1'b1,1'b0,3'd7, 3'd7, 1'b1,1'b0, 8'd10},  // R10 top index
    {1'b0,1'b0,3'd0, 1'b1,1'b1,3'd7, 3'd7, 1'b1,1'b1, 8'd10}   // R10
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    l_sel = 0; l_ce = 0; l_wr = 0; l_oe = 0; l_wdata = '0;
    r_sel = 0; r_ce = 0; r_wr = 0; r_oe = 0; r_wdata = '0;
  endtask

  task automatic read_both(input logic [2:0] a);
    idle();
    l_sel = 1; l_oe = 1; l_addr = a;
    r_sel = 1; r_oe = 1; r_addr = a;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: every flag free after reset
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); read_both(3'(i)); #5;
      check($sformatf("R1 left flag %0d", i), l_rdata, 8'hFF);
      check($sformatf("R1 right flag %0d", i), r_rdata, 8'hFF);
    end

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      idle();
      if (VEC[v][22]) begin
        l_sel = 1; l_wr = 1; l_wdata = {7'b0, VEC[v][21]}; l_addr = VEC[v][20:18];
      end
      if (VEC[v][17]) begin
        r_sel = 1; r_wr = 1; r_wdata = {7'b0, VEC[v][16]}; r_addr = VEC[v][15:13];
      end
      @(negedge clk); read_both(VEC[v][12:10]); #5;
      check($sformatf("R%0d vec %0d left", VEC[v][7:0], v), l_rdata, {8{VEC[v][9]}});
      check($sformatf("R%0d vec %0d right", VEC[v][7:0], v), r_rdata, {8{VEC[v][8]}});
    end

    // R3: write with chip enable high is ignored
    @(negedge clk); idle(); l_sel = 1; l_ce = 1; l_wr = 1; l_addr = 3'd5;
    @(negedge clk); read_both(3'd5); #5;
    check("R3 chip enable blocks write", l_rdata, 8'hFF);
    // R3: write without select is ignored
    @(negedge clk); idle(); r_wr = 1; r_addr = 3'd5;
    @(negedge clk); read_both(3'd5); #5;
    check("R3 no select blocks write", r_rdata, 8'hFF);

    // R4: output gating, with left owning flag 6
    @(negedge clk); idle(); l_sel = 1; l_wr = 1; l_addr = 3'd6;
    @(negedge clk); read_both(3'd6); #5;
    check("R4 owner reads zeros", l_rdata, 8'h00);
    @(negedge clk); read_both(3'd6); r_oe = 0; #5;
    check("R4 output enable low", r_rdata, 8'h00);
    @(negedge clk); read_both(3'd6); r_ce = 1; #5;
    check("R4 chip enable high", r_rdata, 8'h00);
    @(negedge clk); read_both(3'd6); r_sel = 0; #5;
    check("R4 select low", r_rdata, 8'h00);
    @(negedge clk); read_both(3'd6); #5;
    check("R4 other side all ones", r_rdata, 8'hFF);
    // R4: read bus idle during a write strobe (a request on a held flag only waits)
    @(negedge clk); idle(); r_sel = 1; r_oe = 1; r_wr = 1; r_addr = 3'd6; #5;
    check("R4 write strobe mutes bus", r_rdata, 8'h00);

    // R1: reset mid-run clears ownership
    @(negedge clk); idle(); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); read_both(3'd6); #5;
    check("R1 reset frees left", l_rdata, 8'hFF);
    check("R1 reset frees right", r_rdata, 8'hFF);

    @(negedge clk); idle();
    finish_run();
  end
endmodule